// File: doc/BRIEF.md
# Packed-BCD Add/Subtract Unit

An 8-bit arithmetic slice that performs add-with-carry and subtract-with-borrow in either plain binary or packed binary-coded decimal. Two flavours of flag behaviour are available through a parameter: an early-silicon flavour, in which the decimal-mode flags are taken part-way through the digit correction, and a later flavour, in which they follow the corrected result. Both flavours reproduce the exact bit patterns the hardware gives for nibbles holding A to F, not only for valid digits.

The inputs are evaluated in one cycle and the result and the four flags (negative, zero, overflow, carry) are registered, so each answer appears one clock after its operands. A second parameter removes decimal support; the decimal request is then ignored and every operation is binary.

Top module: `dec_alu`

## Requirements
- R1: While reset is asserted all outputs read zero; after reset the result and flags for the operands present at a rising clock edge are visible after that edge and hold until the next.
- R2: In binary mode an add gives result = (A + B + carry_in) mod 256, carry = bit 8 of that sum, overflow = 1 exactly when result bit 7 differs from both A bit 7 and B bit 7, negative = result bit 7, zero = (result == 0).
- R3: In binary mode a subtract (sub_in = 1) is the add of R2 applied to the bitwise complement of B; carry = 1 means no borrow.
- R4: With decimal support disabled by parameter, dec_in has no effect: every operation follows R2 and R3.
- R5: Decimal add low digit: with S the 8-bit binary sum and H the carry from bit 3 into bit 4 of it, if H = 1 then 6 is added to the low nibble alone (mod 16, upper nibble unchanged); otherwise, if the low nibble of S exceeds 9, 6 is added to the whole byte (mod 256) and carry is set if S was at least 0xFA. The value so formed is the partial result P.
- R6: Decimal add high digit: carry is the binary carry out, OR the R5 condition, OR P >= 0xA0; when carry is 1 the result is P + 0x60 (mod 256), otherwise P. For valid BCD operands carry = 1 exactly when the decimal sum exceeds 99.
- R7: Early-flavour decimal add: zero comes from the uncorrected binary sum S, negative is bit 7 of P, and overflow uses P together with the original A and B in the R2 rule.
- R8: Late-flavour decimal add: overflow as in R7, while negative and zero come from the final result; in the late flavour negative and zero always describe the output result.
- R9: Decimal subtract: carry and overflow come from the binary sum of A, the complement of B and carry_in; in the early flavour negative and zero also come from that binary sum.
- R10: Decimal subtract low digit: if the binary sum of R9 had no carry from bit 3 into bit 4, 0xFA is added to the whole byte in the late flavour, but only to the low nibble (mod 16, upper nibble kept) in the early flavour.
- R11: Decimal subtract high digit: if the carry of R9 is 0, 0xA0 is added to the value from R10; in the late flavour negative and zero come from this final value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_in | input | 8 | Accumulator operand |
| b_in | input | 8 | Second operand |
| carry_in | input | 1 | Incoming carry (1 = no borrow for subtract) |
| dec_in | input | 1 | 1 requests packed-BCD arithmetic |
| sub_in | input | 1 | 0 = add, 1 = subtract |
| res_q | output | 8 | Registered result |
| neg_q | output | 1 | Registered negative flag |
| zero_q | output | 1 | Registered zero flag |
| ovf_q | output | 1 | Registered overflow flag |
| carry_q | output | 1 | Registered carry flag |

## Verification
On every cycle the assertions check the binary add and subtract sums, that the decimal request is ignored when support is removed, the decimal-subtract carry, that late-flavour negative and zero track the output result, and the carry of decimal adds of valid digit pairs. The exact corrected results, the points at which early-flavour flags are sampled, and the behaviour on invalid digits can only be shown by the bench, which drives a broad operand sweep through both flavours and a decimal-free instance side by side and compares every output with an independent reference.

// File: rtl/dec_alu_pkg.sv
package dec_alu_pkg;

   typedef enum logic {
      ALU_NMOS = 1'b0,
      ALU_CMOS = 1'b1
   } alu_model_e;

   typedef struct packed {
      logic n;
      logic z;
      logic v;
      logic c;
   } alu_flags_t;

   // signed overflow: result sign disagrees with both source signs
   function automatic logic sign_ovf(input logic r, input logic x, input logic y);
      return (r ^ x) & (r ^ y);
   endfunction

endpackage

// File: rtl/dec_alu_bin.sv
module dec_alu_bin #(
   parameter int DATA_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] opnd,
   input  logic              cin,
   output logic [DATA_W-1:0] sum,
   output logic              cout,
   output logic              half,
   output logic              ovf
);
   import dec_alu_pkg::*;

   logic [DATA_W:0] wide;

   always_comb begin
      wide = {1'b0, a} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
      sum  = wide[DATA_W-1:0];
      cout = wide[DATA_W];
      // carry into the upper digit recovered from the sum bits
      half = a[NIB_W] ^ opnd[NIB_W] ^ sum[NIB_W];
      ovf  = sign_ovf(sum[DATA_W-1], a[DATA_W-1], opnd[DATA_W-1]);
   end
endmodule

// File: rtl/dec_alu_add_fix.sv
module dec_alu_add_fix
   import dec_alu_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter int         NIB_W  = 4,
   parameter alu_model_e MODEL  = ALU_NMOS
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] sum,
   input  logic              cout,
   input  logic              half,
   output logic [DATA_W-1:0] res,
   output alu_flags_t        flg
);
   localparam logic [NIB_W-1:0]  DIG_MAX  = NIB_W'(9);
   localparam logic [NIB_W-1:0]  LO_ADJ   = NIB_W'(6);
   localparam logic [DATA_W-1:0] BYTE_ADJ = DATA_W'(6);
   localparam logic [DATA_W-1:0] WRAP_LIM = DATA_W'((1 << DATA_W) - 6);
   localparam logic [DATA_W-1:0] HI_LIM   = DATA_W'(10 << NIB_W);
   localparam logic [DATA_W-1:0] HI_ADJ   = DATA_W'(6 << NIB_W);

   logic [DATA_W-1:0] part;
   logic              c_lo;
   logic              c_all;

   always_comb begin
      part = sum;
      c_lo = cout;
      if (half) begin
         part[NIB_W-1:0] = sum[NIB_W-1:0] + LO_ADJ;
      end else if (sum[NIB_W-1:0] > DIG_MAX) begin
         c_lo = cout | (sum >= WRAP_LIM);
         part = sum + BYTE_ADJ;
      end
      c_all = c_lo | (part >= HI_LIM);
      res   = c_all ? part + HI_ADJ : part;
      flg.c = c_all;
      flg.v = sign_ovf(part[DATA_W-1], a[DATA_W-1], opnd[DATA_W-1]);
   end

   generate
      if (MODEL == ALU_CMOS) begin : g_late
         assign flg.n = res[DATA_W-1];
         assign flg.z = (res == '0);
      end else begin : g_early
         assign flg.n = part[DATA_W-1];
         assign flg.z = (sum == '0);
      end
   endgenerate
endmodule

// File: rtl/dec_alu_sub_fix.sv
module dec_alu_sub_fix
   import dec_alu_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter int         NIB_W  = 4,
   parameter alu_model_e MODEL  = ALU_NMOS
) (
   input  logic [DATA_W-1:0] sum,
   input  logic              cout,
   input  logic              half,
   input  logic              ovf,
   output logic [DATA_W-1:0] res,
   output alu_flags_t        flg
);
   localparam logic [DATA_W-1:0] LO_BORROW = DATA_W'((1 << DATA_W) - 6);
   localparam logic [DATA_W-1:0] HI_BORROW = DATA_W'(10 << NIB_W);

   logic [DATA_W-1:0] part;

   generate
      if (MODEL == ALU_CMOS) begin : g_late
         // borrow from the low digit ripples into the high digit
         assign part = half ? sum : sum + LO_BORROW;
         assign flg.n = res[DATA_W-1];
         assign flg.z = (res == '0);
      end else begin : g_early
         // low digit fixed in place, high digit untouched
         assign part = half ? sum
                            : {sum[DATA_W-1:NIB_W], sum[NIB_W-1:0] + LO_BORROW[NIB_W-1:0]};
         assign flg.n = sum[DATA_W-1];
         assign flg.z = (sum == '0);
      end
   endgenerate

   assign res   = cout ? part : part + HI_BORROW;
   assign flg.c = cout;
   assign flg.v = ovf;
endmodule

// File: rtl/dec_alu.sv
module dec_alu
   import dec_alu_pkg::*;
#(
   parameter int         DATA_W = 8,
   parameter alu_model_e MODEL  = ALU_NMOS,
   parameter bit         DEC_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] a_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              carry_in,
   input  logic              dec_in,
   input  logic              sub_in,
   output logic [DATA_W-1:0] res_q,
   output logic              neg_q,
   output logic              zero_q,
   output logic              ovf_q,
   output logic              carry_q
);
   localparam int NIB_W = DATA_W / 2;

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("dec_alu: two packed decimal digits need DATA_W of 8");
      end
   endgenerate

   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] sum;
   logic              cout;
   logic              half;
   logic              ovf;
   logic [DATA_W-1:0] res_d;
   alu_flags_t        flg_d;
   alu_flags_t        flg_bin;

   assign opnd = sub_in ? ~b_in : b_in;

   dec_alu_bin #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_bin (
      .a   (a_in),
      .opnd(opnd),
      .cin (carry_in),
      .sum (sum),
      .cout(cout),
      .half(half),
      .ovf (ovf)
   );

   assign flg_bin.n = sum[DATA_W-1];
   assign flg_bin.z = (sum == '0);
   assign flg_bin.v = ovf;
   assign flg_bin.c = cout;

   generate
      if (DEC_EN) begin : g_dec
         logic [DATA_W-1:0] res_add;
         logic [DATA_W-1:0] res_sub;
         alu_flags_t        flg_add;
         alu_flags_t        flg_sub;

         dec_alu_add_fix #(.DATA_W(DATA_W), .NIB_W(NIB_W), .MODEL(MODEL)) u_add (
            .a   (a_in),
            .opnd(opnd),
            .sum (sum),
            .cout(cout),
            .half(half),
            .res (res_add),
            .flg (flg_add)
         );

         dec_alu_sub_fix #(.DATA_W(DATA_W), .NIB_W(NIB_W), .MODEL(MODEL)) u_sub (
            .sum (sum),
            .cout(cout),
            .half(half),
            .ovf (ovf),
            .res (res_sub),
            .flg (flg_sub)
         );

         always_comb begin
            if (!dec_in) begin
               res_d = sum;
               flg_d = flg_bin;
            end else if (sub_in) begin
               res_d = res_sub;
               flg_d = flg_sub;
            end else begin
               res_d = res_add;
               flg_d = flg_add;
            end
         end
      end else begin : g_bin_only
         logic unused_dec;
         assign unused_dec = dec_in | half;
         assign res_d = sum;
         assign flg_d = flg_bin;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         neg_q   <= 1'b0;
         zero_q  <= 1'b0;
         ovf_q   <= 1'b0;
         carry_q <= 1'b0;
      end else begin
         res_q   <= res_d;
         neg_q   <= flg_d.n;
         zero_q  <= flg_d.z;
         ovf_q   <= flg_d.v;
         carry_q <= flg_d.c;
      end
   end
endmodule

// File: rtl/dec_alu_chk.sv
module dec_alu_chk #(
   parameter int DATA_W  = 8,
   parameter bit IS_CMOS = 1'b0,
   parameter bit DEC_EN  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] a_in,
   input logic [DATA_W-1:0] b_in,
   input logic              carry_in,
   input logic              dec_in,
   input logic              sub_in,
   input logic [DATA_W-1:0] res_q,
   input logic              neg_q,
   input logic              zero_q,
   input logic              ovf_q,
   input logic              carry_q
);
   logic            past_ok;
   logic            dec_eff;
   logic [DATA_W:0] sum_add;
   logic [DATA_W:0] sum_sub;
   logic            bcd_ok;
   logic [7:0]      dec_total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign dec_eff = DEC_EN & dec_in;
   assign sum_add = {1'b0, a_in} + {1'b0, b_in} + {{DATA_W{1'b0}}, carry_in};
   assign sum_sub = {1'b0, a_in} + {1'b0, ~b_in} + {{DATA_W{1'b0}}, carry_in};
   assign bcd_ok  = (a_in[7:4] < 4'd10) && (a_in[3:0] < 4'd10) &&
                    (b_in[7:4] < 4'd10) && (b_in[3:0] < 4'd10);
   assign dec_total = 8'(a_in[7:4]) * 8'd10 + 8'(a_in[3:0]) +
                      8'(b_in[7:4]) * 8'd10 + 8'(b_in[3:0]) + 8'(carry_in);

   AST_BIN_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(dec_eff) && !$past(sub_in) |-> {carry_q, res_q} == $past(sum_add)); // R2

   AST_BIN_SUB: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(dec_eff) && $past(sub_in) |-> {carry_q, res_q} == $past(sum_sub)); // R3

   AST_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !DEC_EN |-> zero_q == (res_q == '0) && neg_q == res_q[DATA_W-1]); // R4

   AST_LATE_NZ: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && IS_CMOS |-> zero_q == (res_q == '0) && neg_q == res_q[DATA_W-1]); // R8

   AST_DEC_SUB_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(dec_eff) && $past(sub_in) |-> carry_q == $past(sum_sub[DATA_W])); // R9

   AST_BCD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(dec_eff && !sub_in && bcd_ok) |-> carry_q == ($past(dec_total) > 8'd99)); // R6
endmodule

bind dec_alu dec_alu_chk #(
   .DATA_W (DATA_W),
   .IS_CMOS(MODEL == dec_alu_pkg::ALU_CMOS),
   .DEC_EN (DEC_EN)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .a_in    (a_in),
   .b_in    (b_in),
   .carry_in(carry_in),
   .dec_in  (dec_in),
   .sub_in  (sub_in),
   .res_q   (res_q),
   .neg_q   (neg_q),
   .zero_q  (zero_q),
   .ovf_q   (ovf_q),
   .carry_q (carry_q)
);

// File: tb/dec_alu_test.sv
`timescale 1ns/1ps
module dec_alu_test;
   import dec_alu_pkg::*;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a_in = '0;
   logic [7:0] b_in = '0;
   logic       carry_in = 1'b0;
   logic       dec_in = 1'b0;
   logic       sub_in = 1'b0;

   logic [7:0] r_n, r_c, r_b;
   logic       n_n, z_n, v_n, c_n;
   logic       n_c, z_c, v_c, c_c;
   logic       n_b, z_b, v_b, c_b;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   dec_alu #(.MODEL(ALU_NMOS), .DEC_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
      .dec_in(dec_in), .sub_in(sub_in), .res_q(r_n), .neg_q(n_n), .zero_q(z_n),
      .ovf_q(v_n), .carry_q(c_n));

   dec_alu #(.MODEL(ALU_CMOS), .DEC_EN(1'b1)) uut_cmos (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
      .dec_in(dec_in), .sub_in(sub_in), .res_q(r_c), .neg_q(n_c), .zero_q(z_c),
      .ovf_q(v_c), .carry_q(c_c));

   dec_alu #(.MODEL(ALU_NMOS), .DEC_EN(1'b0)) uut_nodec (
      .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in), .carry_in(carry_in),
      .dec_in(dec_in), .sub_in(sub_in), .res_q(r_b), .neg_q(n_b), .zero_q(z_b),
      .ovf_q(v_b), .carry_q(c_b));

   typedef struct packed {
      logic [7:0]  a;
      logic [7:0]  b;
      logic        c;
      logic        dec;
      logic        sub;
      logic [11:0] exp_n;
      logic [11:0] exp_c;
      logic [11:0] exp_b;
   } item_t;

   item_t sb[$];

   // reference from the requirements; returns {n, z, v, c, result}
   function automatic logic [11:0] ref_calc(input logic [7:0] a, input logic [7:0] b,
                                            input logic c, input logic dec, input logic sub,
                                            input logic late, input logic has_dec);
      logic [7:0] o, s, p, f;
      logic [8:0] w;
      logic cy, h, n, z, v;
      o  = sub ? ~b : b;
      w  = 9'(a) + 9'(o) + 9'(c);
      s  = w[7:0];
      cy = w[8];
      h  = a[4] ^ o[4] ^ s[4];
      v  = (s[7] ^ a[7]) & (s[7] ^ o[7]);
      f  = s;
      n  = s[7];
      z  = (s == 8'h00);
      if (dec && has_dec) begin
         if (!sub) begin
            p = s;
            if (h) p[3:0] = s[3:0] + 4'h6;
            else if (s[3:0] > 4'h9) begin
               if (s >= 8'hFA) cy = 1'b1;
               p = s + 8'h06;
            end
            v = (p[7] ^ a[7]) & (p[7] ^ o[7]);
            if (p >= 8'hA0) cy = 1'b1;
            f = cy ? p + 8'h60 : p;
            n = late ? f[7] : p[7];
            z = late ? (f == 8'h00) : (s == 8'h00);
         end else begin
            p = s;
            if (!h) begin
               if (late) p = s + 8'hFA;
               else      p[3:0] = s[3:0] + 4'hA;
            end
            f = cy ? p : p + 8'hA0;
            if (late) begin
               n = f[7];
               z = (f == 8'h00);
            end
         end
      end
      return {n, z, v, cy, f};
   endfunction

   function automatic string tag_of(input item_t it, input logic [11:0] got,
                                    input logic [11:0] exp, input logic late,
                                    input logic has_dec);
      if (!has_dec) return "R4";
      if (!it.dec) return it.sub ? "R3" : "R2";
      if (!it.sub) begin
         if (got[7:0] != exp[7:0]) return "R5";
         if (got[8] != exp[8]) return "R6";
         return late ? "R8" : "R7";
      end
      if (got[7:0] != exp[7:0]) return "R10";
      if (got[9:8] != exp[9:8]) return "R9";
      return late ? "R11" : "R9";
   endfunction

   task automatic compare(input item_t it, input logic [11:0] got, input logic [11:0] exp,
                          input logic late, input logic has_dec, input string who);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s %s a=%h b=%h c=%b dec=%b sub=%b got nzvc=%b res=%h expected nzvc=%b res=%h",
                  tag_of(it, got, exp, late, has_dec), who, it.a, it.b, it.c, it.dec, it.sub,
                  got[11:8], got[7:0], exp[11:8], exp[7:0]);
      end
   endtask

   // driver: apply one operation and push what all three instances must return
   task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic c,
                        input logic dec, input logic sub);
      item_t it;
      @(negedge clk);
      a_in = a; b_in = b; carry_in = c; dec_in = dec; sub_in = sub;
      it.a = a; it.b = b; it.c = c; it.dec = dec; it.sub = sub;
      it.exp_n = ref_calc(a, b, c, dec, sub, 1'b0, 1'b1);
      it.exp_c = ref_calc(a, b, c, dec, sub, 1'b1, 1'b1);
      it.exp_b = ref_calc(a, b, c, dec, sub, 1'b0, 1'b0);
      sb.push_back(it);
   endtask

   // monitor: one registered answer per edge after each drive
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            item_t it;
            it = sb.pop_front();
            compare(it, {n_n, z_n, v_n, c_n, r_n}, it.exp_n, 1'b0, 1'b1, "early");
            compare(it, {n_c, z_c, v_c, c_c, r_c}, it.exp_c, 1'b1, 1'b1, "late");
            compare(it, {n_b, z_b, v_b, c_b, r_b}, it.exp_b, 1'b0, 1'b0, "nodec");
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired before the sweep completed");
      finish_run();
   end

   initial begin
      // R1: reset state with non-zero inputs applied
      a_in = 8'hFF; b_in = 8'hFF; carry_in = 1'b1; dec_in = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if ({r_n, n_n, z_n, v_n, c_n, r_c, n_c, z_c, v_c, c_c, r_b, n_b, z_b, v_b, c_b} !== '0) begin
         bad++;
         $display("FAIL R1 reset outputs got %h/%h/%h expected 00 with flags clear", r_n, r_c, r_b);
      end
      rst_n = 1'b1;

      // directed corners: R5 half-carry fix, R6 99+99+1, R10 invalid digits, R11 borrow out
      drive(8'h09, 8'h09, 1'b0, 1'b1, 1'b0);
      drive(8'h99, 8'h99, 1'b1, 1'b1, 1'b0);
      drive(8'h99, 8'h01, 1'b0, 1'b1, 1'b0);
      drive(8'hFF, 8'hFF, 1'b1, 1'b1, 1'b0);
      drive(8'h00, 8'h01, 1'b1, 1'b1, 1'b1);
      drive(8'h10, 8'h0F, 1'b1, 1'b1, 1'b1);
      drive(8'h0A, 8'hAF, 1'b0, 1'b1, 1'b1);
      drive(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
      drive(8'h80, 8'h01, 1'b1, 1'b0, 1'b1);

      // sweep: every A, 52 B values per A rotated so all B values occur, all modes
      for (int a = 0; a < 256; a++) begin
         for (int j = 0; j < 52; j++) begin
            for (int m = 0; m < 8; m++) begin
               drive(8'(a), 8'((j * 5 + a) % 256), m[0], m[1], m[2]);
            end
         end
      end

      repeat (4) @(posedge clk);
      #2;
      finish_run();
   end
endmodule